// File: doc/BRIEF.md
# Cascadable LCD Segment Data Capture

This block is the digital front end of a 160-column LCD segment driver. On each falling edge of a data clock it accepts one transfer from a parallel bus, either a byte or a nibble. It accepts data only while its active-low chain enable is asserted. Each transfer is shifted into a column register. A direction input sets which end of the panel row the register fills from. When the last transfer of a line has arrived, the block ignores further clocks and pulls its enable output low, which hands the bus to the next device in the chain.

A falling edge of the load strobe copies the column register into a display latch. The same edge restarts the transfer count and returns the enable output to its inactive level, so the next line again starts at the first device. Each latched bit is combined with the frame alternation input and an active-low blanking input. The result is a 2-bit drive-level code per column, which the analog output stage would use to pick one of four voltages.

All strobe inputs are sampled by a fast system clock `clk`. Their falling edges are detected in that clock domain. Both chain pins exist as separate input, output and output-enable signals, so the pad ring can form the two bidirectional pins from them.

Top module: `lcdSegCapture`

## Requirements
- R1: After reset the transfer count is zero, the chain output that is currently in the output role is high, and the display latch holds all zeros, so every column reports code 1 while `altPhase` is high and `blankN` is high.
- R2: With `wideBus`=1 and `fillFromHigh`=0, a full line holds 20 byte transfers. Transfer t (counting from 0) lands on columns 8t+1..8t+8, with column 8t+1 taking `dataIn[7]` and column 8t+8 taking `dataIn[0]`.
- R3: With `wideBus`=1 and `fillFromHigh`=1, transfer t lands on columns 160-8t down to 153-8t, with column 160-8t taking `dataIn[7]` and column 153-8t taking `dataIn[0]`.
- R4: With `wideBus`=0, a line holds 40 nibble transfers taken from `dataIn[3:0]` only, and `dataIn[7:4]` has no effect. The placement matches R2 and R3 with a width of 4, so `dataIn[3]` goes to column 4t+1 when `fillFromHigh`=0 and to column 160-4t when `fillFromHigh`=1.
- R5: With `fillFromHigh`=0, `chainInA` is the enable input, `chainOeB`=1 and `chainOeA`=0. With `fillFromHigh`=1 the roles swap: `chainInB` is the input, `chainOeA`=1 and `chainOeB`=0. The non-selected chain input has no effect.
- R6: While the selected chain input is high, falling edges of `dataClk` leave the column register unchanged.
- R7: Once a full line (20 or 40 transfers) has been taken, the driven chain output goes low and further `dataClk` edges leave the column register unchanged.
- R8: A falling edge of `loadStrobe` copies the column register into the display latch, clears the transfer count and returns the driven chain output to high.
- R9: With `blankN`=1, a column's code is 0 for `altPhase`=1 and bit 1, 1 for `altPhase`=1 and bit 0, 2 for `altPhase`=0 and bit 0, and 3 for `altPhase`=0 and bit 1.
- R10: With `blankN`=0, every column's code is 3, whatever the latched bit and `altPhase` are.
- R11: The codes do not change while a new line is being shifted in. They change only after a load edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all strobes |
| rstN | input | 1 | Active-low asynchronous reset |
| dataClk | input | 1 | Transfer clock; falling edge takes one transfer |
| loadStrobe | input | 1 | Line load; falling edge copies the register into the latch |
| wideBus | input | 1 | 1 = 8-bit transfers, 0 = 4-bit transfers |
| fillFromHigh | input | 1 | 0 = fill starts at column 1, 1 = fill starts at column 160 |
| dataIn | input | 8 | Parallel display data |
| chainInA | input | 1 | Chain pin A input value |
| chainInB | input | 1 | Chain pin B input value |
| chainOutA | output | 1 | Chain pin A output value |
| chainOeA | output | 1 | Chain pin A output enable |
| chainOutB | output | 1 | Chain pin B output value |
| chainOeB | output | 1 | Chain pin B output enable |
| altPhase | input | 1 | Frame alternation input |
| blankN | input | 1 | Active-low display blanking |
| levelCode | output | 320 | 2-bit drive code per column; column c at bits [2c-1:2c-2] |

## Verification
Full lines are sent with bytes and with nibbles, in each fill direction. Each transfer carries a distinct value that depends on its position, so a swapped bit order, a wrong start end or a wrong step width moves visible bits. In nibble mode the upper bus bits carry values that differ from the lower nibble, which exposes any leak from the unused half of the bus. Extra clocks after a line is complete, clocks with the enable held inactive, and a toggling non-selected chain input must leave the previous line intact after the next load. Each line is read back under both alternation phases and with blanking asserted, which tells the four level codes apart.

// File: rtl/lcdSegPkg.sv
package lcdSegPkg;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftEn;   // take one transfer into the column register
    logic lineLoad;  // copy column register into display latch
  } segStrobe_t;

  // drive-level codes seen by the analog stage
  typedef enum logic [1:0] {
    LVL_SEL_HI   = 2'd0,
    LVL_UNSEL_HI = 2'd1,
    LVL_UNSEL_LO = 2'd2,
    LVL_SEL_LO   = 2'd3
  } driveLevel_t;

endpackage

// File: rtl/lcdSegCtrl.sv
module lcdSegCtrl
  import lcdSegPkg::*;
#(
  parameter int NUM_COLS = 160,
  parameter int BUS_MAX  = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       dataClk,
  input  logic       loadStrobe,
  input  logic       wideBus,
  input  logic       fillFromHigh,
  input  logic       chainInA,
  input  logic       chainInB,
  output segStrobe_t strb,
  output logic       chainOutA,
  output logic       chainOeA,
  output logic       chainOutB,
  output logic       chainOeB
);

  localparam int XFER_WIDE   = NUM_COLS / BUS_MAX;
  localparam int XFER_NARROW = NUM_COLS / (BUS_MAX / 2);
  localparam int CNT_W       = $clog2(XFER_NARROW + 1);
  localparam logic [CNT_W-1:0] LIMIT_WIDE   = CNT_W'(XFER_WIDE);
  localparam logic [CNT_W-1:0] LIMIT_NARROW = CNT_W'(XFER_NARROW);

  logic             cpPrev;
  logic             ldPrev;
  logic             cpFall;
  logic             ldFall;
  logic             chainSel;
  logic             lineDone;
  logic [CNT_W-1:0] xferCnt;
  logic [CNT_W-1:0] xferLimit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpPrev <= 1'b0;
      ldPrev <= 1'b0;
    end else begin
      cpPrev <= dataClk;
      ldPrev <= loadStrobe;
    end
  end

  assign cpFall    = cpPrev & ~dataClk;
  assign ldFall    = ldPrev & ~loadStrobe;
  assign chainSel  = fillFromHigh ? chainInB : chainInA;
  assign xferLimit = wideBus ? LIMIT_WIDE : LIMIT_NARROW;
  assign lineDone  = (xferCnt >= xferLimit);

  // load has priority over a coincident transfer edge
  always_comb begin
    strb.lineLoad = ldFall;
    strb.shiftEn  = cpFall & ~chainSel & ~lineDone & ~ldFall;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xferCnt <= '0;
    end else if (ldFall) begin
      xferCnt <= '0;
    end else if (strb.shiftEn) begin
      xferCnt <= xferCnt + 1'b1;
    end
  end

  // the pin not used as input drives the active-low token
  always_comb begin
    chainOeA  = fillFromHigh;
    chainOeB  = ~fillFromHigh;
    chainOutA = fillFromHigh ? ~lineDone : 1'b1;
    chainOutB = fillFromHigh ? 1'b1 : ~lineDone;
  end

  a_r8_load_clears: assert property (@(posedge clk) disable iff (!rstN)
    $fell(loadStrobe) |=> (xferCnt == '0));

  a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    xferCnt <= LIMIT_NARROW);

  a_r7_count_step: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftEn |=> (xferCnt == $past(xferCnt) + 1'b1));

endmodule

// File: rtl/lcdSegDatapath.sv
module lcdSegDatapath
  import lcdSegPkg::*;
#(
  parameter int NUM_COLS = 160,
  parameter int BUS_MAX  = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  segStrobe_t            strb,
  input  logic                  wideBus,
  input  logic                  fillFromHigh,
  input  logic [BUS_MAX-1:0]    dataIn,
  input  logic                  altPhase,
  input  logic                  blankN,
  output logic [2*NUM_COLS-1:0] levelCode
);

  localparam int HALF = BUS_MAX / 2;

  logic [NUM_COLS-1:0] shiftReg;
  logic [NUM_COLS-1:0] shiftNext;
  logic [NUM_COLS-1:0] dispLatch;

  // bit 0 of the register is column 1
  always_comb begin
    shiftNext = shiftReg;
    if (wideBus) begin
      if (!fillFromHigh) begin
        shiftNext = shiftReg >> BUS_MAX;
        for (int k = 0; k < BUS_MAX; k++)
          shiftNext[NUM_COLS-BUS_MAX+k] = dataIn[BUS_MAX-1-k];
      end else begin
        shiftNext = shiftReg << BUS_MAX;
        for (int k = 0; k < BUS_MAX; k++)
          shiftNext[k] = dataIn[k];
      end
    end else begin
      if (!fillFromHigh) begin
        shiftNext = shiftReg >> HALF;
        for (int k = 0; k < HALF; k++)
          shiftNext[NUM_COLS-HALF+k] = dataIn[HALF-1-k];
      end else begin
        shiftNext = shiftReg << HALF;
        for (int k = 0; k < HALF; k++)
          shiftNext[k] = dataIn[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      dispLatch <= '0;
    end else begin
      if (strb.shiftEn)  shiftReg  <= shiftNext;
      if (strb.lineLoad) dispLatch <= shiftReg;
    end
  end

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    driveLevel_t colLvl;
    always_comb begin
      if (!blankN)       colLvl = LVL_SEL_LO;
      else if (altPhase) colLvl = dispLatch[c] ? LVL_SEL_HI : LVL_UNSEL_HI;
      else               colLvl = dispLatch[c] ? LVL_SEL_LO : LVL_UNSEL_LO;
    end
    assign levelCode[2*c +: 2] = colLvl;
  end

  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shiftEn |=> $stable(shiftReg));

  a_r8_latch_copy: assert property (@(posedge clk) disable iff (!rstN)
    strb.lineLoad |=> (dispLatch == $past(shiftReg)));

  a_r11_latch_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.lineLoad |=> $stable(dispLatch));

endmodule

// File: rtl/lcdSegCapture.sv
module lcdSegCapture
  import lcdSegPkg::*;
#(
  parameter int NUM_COLS = 160,
  parameter int BUS_MAX  = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  dataClk,
  input  logic                  loadStrobe,
  input  logic                  wideBus,
  input  logic                  fillFromHigh,
  input  logic [BUS_MAX-1:0]    dataIn,
  input  logic                  chainInA,
  input  logic                  chainInB,
  output logic                  chainOutA,
  output logic                  chainOeA,
  output logic                  chainOutB,
  output logic                  chainOeB,
  input  logic                  altPhase,
  input  logic                  blankN,
  output logic [2*NUM_COLS-1:0] levelCode
);

  segStrobe_t strb;

  lcdSegCtrl #(.NUM_COLS(NUM_COLS), .BUS_MAX(BUS_MAX)) ctrl (
    .clk(clk), .rstN(rstN), .dataClk(dataClk), .loadStrobe(loadStrobe),
    .wideBus(wideBus), .fillFromHigh(fillFromHigh),
    .chainInA(chainInA), .chainInB(chainInB), .strb(strb),
    .chainOutA(chainOutA), .chainOeA(chainOeA),
    .chainOutB(chainOutB), .chainOeB(chainOeB)
  );

  lcdSegDatapath #(.NUM_COLS(NUM_COLS), .BUS_MAX(BUS_MAX)) dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wideBus(wideBus),
    .fillFromHigh(fillFromHigh), .dataIn(dataIn), .altPhase(altPhase),
    .blankN(blankN), .levelCode(levelCode)
  );

endmodule

// File: tb/lcdSegCapture_test.sv
module lcdSegCapture_test;

  localparam int NC = 160;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dataClk = 1'b0, loadStrobe = 1'b0, wideBus = 1'b1, fillFromHigh = 1'b0;
  logic [7:0] dataIn = '0;
  logic chainInA = 1'b0, chainInB = 1'b1;
  logic chainOutA, chainOeA, chainOutB, chainOeB;
  logic altPhase = 1'b1, blankN = 1'b1;
  logic [2*NC-1:0] levelCode;

  int checks = 0;
  int failures = 0;
  logic [NC-1:0] expBits = '0;

  always #2.5 clk = ~clk;

  lcdSegCapture uut (
    .clk(clk), .rstN(rstN), .dataClk(dataClk), .loadStrobe(loadStrobe),
    .wideBus(wideBus), .fillFromHigh(fillFromHigh), .dataIn(dataIn),
    .chainInA(chainInA), .chainInB(chainInB),
    .chainOutA(chainOutA), .chainOeA(chainOeA),
    .chainOutB(chainOutB), .chainOeB(chainOeB),
    .altPhase(altPhase), .blankN(blankN), .levelCode(levelCode)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cpPulse(input logic [7:0] v);
    @(negedge clk);
    dataIn = v;
    dataClk = 1'b1;
    idle(2);
    dataClk = 1'b0;
    idle(2);
  endtask

  task automatic loadPulse();
    @(negedge clk);
    loadStrobe = 1'b1;
    idle(2);
    loadStrobe = 1'b0;
    idle(3);
  endtask

  // sends n transfers; the model records only those that fit in a line
  task automatic sendLine(input int n, input int seed, input bit track);
    int w;
    int lim;
    w = wideBus ? 8 : 4;
    lim = NC / w;
    for (int t = 0; t < n; t++) begin
      logic [7:0] d;
      d = 8'((seed * 7 + t * 29 + 3) & 255);
      if (!wideBus) d = {d[3:0] ^ 4'hA ^ 4'(t), d[3:0]};
      cpPulse(d);
      if (track && t < lim) begin
        for (int k = 0; k < w; k++) begin
          int col;
          col = fillFromHigh ? (NC - 1 - (t * w + k)) : (t * w + k);
          expBits[col] = d[w-1-k];
        end
      end
    end
  endtask

  // compares every column against the code table of R9/R10
  task automatic checkLevels(input string req);
    int bad;
    int badCol;
    int act;
    int exp;
    bad = 0; badCol = 0; act = 0; exp = 0;
    for (int c = 0; c < NC; c++) begin
      int e;
      int a;
      if (!blankN)       e = 3;
      else if (altPhase) e = expBits[c] ? 0 : 1;
      else               e = expBits[c] ? 3 : 2;
      a = int'(levelCode[2*c +: 2]);
      if (a != e && bad == 0) begin
        bad = 1; badCol = c + 1; act = a; exp = e;
      end
    end
    if (bad != 0) $display("FAIL %s first bad column %0d", req, badCol);
    check(bad == 0, req, act, exp);
  endtask

  function automatic logic drivenOut();
    return fillFromHigh ? chainOutA : chainOutB;
  endfunction

  task automatic testReset();
    check(drivenOut() == 1'b1, "R1 chain idle high", int'(drivenOut()), 1);
    expBits = '0;
    checkLevels("R1 reset codes");
  endtask

  task automatic testWideLow();
    wideBus = 1'b1; fillFromHigh = 1'b0; chainInA = 1'b0; chainInB = 1'b1;
    idle(2);
    check(chainOeB == 1'b1 && chainOeA == 1'b0, "R5 roles low", int'({chainOeA, chainOeB}), 1);
    sendLine(19, 1, 1'b1);
    check(chainOutB == 1'b1, "R7 token before full", int'(chainOutB), 1);
    sendLine(1, 50, 1'b0);
    expBits[152 +: 8] = {<<{8'((50 * 7 + 3) & 255)}};
    check(chainOutB == 1'b0, "R7 token after 20", int'(chainOutB), 0);
    loadPulse();
    check(chainOutB == 1'b1, "R8 token released", int'(chainOutB), 1);
    altPhase = 1'b1; idle(1);
    checkLevels("R2 wide low line M high");
    altPhase = 1'b0; idle(1);
    checkLevels("R9 wide low line M low");
    altPhase = 1'b1;
  endtask

  task automatic testWideHigh();
    wideBus = 1'b1; fillFromHigh = 1'b1; chainInB = 1'b0; chainInA = 1'b1;
    idle(2);
    check(chainOeA == 1'b1 && chainOeB == 1'b0, "R5 roles high", int'({chainOeA, chainOeB}), 2);
    sendLine(20, 2, 1'b1);
    check(chainOutA == 1'b0, "R7 token on pin A", int'(chainOutA), 0);
    loadPulse();
    checkLevels("R3 wide high line");
    check(chainOutA == 1'b1, "R8 token released A", int'(chainOutA), 1);
  endtask

  task automatic testNarrow();
    wideBus = 1'b0; fillFromHigh = 1'b0; chainInA = 1'b0; chainInB = 1'b1;
    idle(2);
    sendLine(40, 3, 1'b1);
    check(chainOutB == 1'b0, "R7 token after 40 nibbles", int'(chainOutB), 0);
    loadPulse();
    checkLevels("R4 narrow low line");
    fillFromHigh = 1'b1; chainInB = 1'b0; chainInA = 1'b1;
    idle(2);
    sendLine(40, 4, 1'b1);
    loadPulse();
    altPhase = 1'b0; idle(1);
    checkLevels("R4 narrow high line");
    altPhase = 1'b1;
  endtask

  task automatic testStandbyAndHold();
    wideBus = 1'b1; fillFromHigh = 1'b0; chainInA = 1'b0; chainInB = 1'b1;
    idle(2);
    sendLine(20, 5, 1'b1);
    loadPulse();
    checkLevels("R8 base line");
    // enable inactive: transfers must be dropped; other pin toggled
    chainInA = 1'b1; chainInB = 1'b0;
    idle(2);
    sendLine(20, 9, 1'b0);
    check(chainOutB == 1'b1, "R6 no count in standby", int'(chainOutB), 1);
    loadPulse();
    checkLevels("R6 standby keeps register");
    // new line in progress must not disturb the codes
    chainInA = 1'b0; chainInB = 1'b1;
    idle(2);
    sendLine(10, 11, 1'b0);
    checkLevels("R11 codes held during shift");
    loadPulse();
  endtask

  task automatic testOverfill();
    wideBus = 1'b1; fillFromHigh = 1'b0; chainInA = 1'b0;
    idle(2);
    sendLine(20, 13, 1'b1);
    sendLine(6, 77, 1'b0);
    loadPulse();
    checkLevels("R7 extra transfers ignored");
  endtask

  task automatic testBlank();
    blankN = 1'b0; altPhase = 1'b1; idle(1);
    checkLevels("R10 blank M high");
    altPhase = 1'b0; idle(1);
    checkLevels("R10 blank M low");
    blankN = 1'b1; altPhase = 1'b1; idle(1);
    checkLevels("R9 unblank restores");
  endtask

  bit finished = 1'b0;

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(3);
    testReset();
    testWideLow();
    testWideHigh();
    testNarrow();
    testStandbyAndHold();
    testOverfill();
    testBlank();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule